// File: doc/BRIEF.md
# Saturating Multiply-Accumulate Unit

This block keeps a 64-bit signed accumulator, seen from outside as a high word and a low word. Each accepted request multiplies two signed operands and adds the product to the accumulator. The long form uses the full 32-bit operands. The word form uses only the low 16 bits of each operand. A saturation-mode bit picks between plain wrap-around addition and a bounded result. The two forms bound the result in different ways. The long form limits the high word to a 48-bit signed range. The word form clamps the low word to the 32-bit signed range and flags the overflow in the high word.

Software or a sequencer can load either word directly, zero both words with a clear command, or leave the accumulator idle. One command is chosen per cycle by a fixed priority: clear, then multiply-accumulate, then word load, then hold. The chosen command updates the accumulator on the next rising clock edge. The new words are visible on the outputs in the cycle after that edge.

Top module: `smac_unit`

## Requirements
- R1: A synchronous active-high `rst` sets both `acc_hi` and `acc_lo` to zero on the next rising edge, whatever the other inputs are.
- R2: When `clr` is high, both words become zero on the next edge. This takes priority over a multiply-accumulate and over word loads issued in the same cycle.
- R3: When there is no clear and no valid request, `wr_hi` loads `wr_data` into the high word and `wr_lo` loads `wr_data` into the low word on the next edge. The two enables act independently.
- R4: With `in_valid` high and `op_word` = 0 (long form), both 32-bit operands are sign-extended and their full product is added to {acc_hi, acc_lo}. With `sat_en` = 0 the sum wraps modulo 2^64.
- R5: With `op_word` = 1 (word form), only bits 15..0 of each operand are used, sign-extended. Bits 31..16 of the operands have no effect on the result.
- R6: Long form with `sat_en` = 1: the low word is bits 31..0 of the sum. If the 64-bit sum is negative, bits 31..16 of the high word are forced to ones. Otherwise bits 31..15 of the high word are forced to zero. The remaining high-word bits come from the sum.
- R7: Word form with `sat_en` = 1: a sum below -2^31 gives acc_lo = 0x80000000 and acc_hi = 1. A sum above 2^31-1 gives acc_lo = 0x7FFFFFFF and acc_hi = 1. Any other sum is kept whole.
- R8: A valid request takes priority over word loads in the same cycle. With no command active, both words hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Multiply-accumulate request strobe |
| op_word | input | 1 | 0 = long (32x32) form, 1 = word (16x16) form |
| sat_en | input | 1 | 1 = saturating accumulation |
| opa | input | 32 | First multiplicand |
| opb | input | 32 | Second multiplicand |
| clr | input | 1 | Zero both accumulator words |
| wr_hi | input | 1 | Load `wr_data` into the high word |
| wr_lo | input | 1 | Load `wr_data` into the low word |
| wr_data | input | 32 | Data for word loads |
| acc_hi | output | 32 | Accumulator bits 63..32 |
| acc_lo | output | 32 | Accumulator bits 31..0 |

## Verification
The long form is tried with positive and mixed-sign operands and with the most negative operand squared, which shows whether the product is sign-extended correctly. It is also tried on a preloaded accumulator that wraps past the largest positive value. The word form is given operands whose upper halves hold unrelated data, so any leak of those bits shows up in the result. Saturation is driven across both word-form bounds, once with a result inside them, and on positive and negative long-form sums. Each of these cases tells the two clamping schemes apart. Same-cycle clear, request and load combinations, together with idle cycles, test the command priority.

// File: rtl/smac_pkg.sv
package smac_pkg;
    // Command chosen for the accumulator in one cycle, by priority
    typedef enum logic [1:0] {
        CMD_HOLD  = 2'd0,
        CMD_LOAD  = 2'd1,
        CMD_MAC   = 2'd2,
        CMD_CLEAR = 2'd3
    } acc_cmd_t;
endpackage

// File: rtl/smac_mult.sv
module smac_mult #(
    parameter int DATA_W = 32,
    parameter int HALF_W = 16,
    localparam int ACC_W = 2 * DATA_W
) (
    input  logic              op_word,
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    output logic [ACC_W-1:0]  prod
);
    logic signed [ACC_W-1:0] long_a, long_b, word_a, word_b;
    logic signed [ACC_W-1:0] long_p, word_p;

    always_comb begin
        long_a = {{DATA_W{opa[DATA_W-1]}}, opa};
        long_b = {{DATA_W{opb[DATA_W-1]}}, opb};
        word_a = {{(ACC_W-HALF_W){opa[HALF_W-1]}}, opa[HALF_W-1:0]};
        word_b = {{(ACC_W-HALF_W){opb[HALF_W-1]}}, opb[HALF_W-1:0]};
        long_p = long_a * long_b;
        word_p = word_a * word_b;
        prod   = op_word ? word_p : long_p;
    end
endmodule

// File: rtl/smac_sat.sv
module smac_sat #(
    parameter int DATA_W  = 32,
    parameter int GUARD_W = 48,
    localparam int ACC_W  = 2 * DATA_W,
    localparam int FILL_LO = GUARD_W - DATA_W
) (
    input  logic             sat_en,
    input  logic             op_word,
    input  logic [ACC_W-1:0] sum,
    output logic [ACC_W-1:0] result
);
    localparam logic [ACC_W-1:0] WORD_MIN = {{(DATA_W+1){1'b1}}, {(DATA_W-1){1'b0}}};
    localparam logic [ACC_W-1:0] WORD_MAX = {{(DATA_W+1){1'b0}}, {(DATA_W-1){1'b1}}};
    localparam logic [DATA_W-1:0] FLAG_HI = {{(DATA_W-1){1'b0}}, 1'b1};
    localparam logic [DATA_W-1:0] LO_MIN  = {1'b1, {(DATA_W-1){1'b0}}};
    localparam logic [DATA_W-1:0] LO_MAX  = {1'b0, {(DATA_W-1){1'b1}}};

    logic [DATA_W-1:0] long_hi;
    logic              below, above;

    always_comb begin
        long_hi = sum[ACC_W-1:DATA_W];
        if (sum[ACC_W-1]) begin
            long_hi[DATA_W-1:FILL_LO] = '1;
        end else begin
            long_hi[DATA_W-1:FILL_LO-1] = '0;
        end
        below = $signed(sum) < $signed(WORD_MIN);
        above = $signed(sum) > $signed(WORD_MAX);
    end

    always_comb begin
        result = sum;
        if (sat_en) begin
            if (!op_word) begin
                result = {long_hi, sum[DATA_W-1:0]};
            end else if (below) begin
                result = {FLAG_HI, LO_MIN};
            end else if (above) begin
                result = {FLAG_HI, LO_MAX};
            end
        end
    end
endmodule

// File: rtl/smac_acc.sv
module smac_acc
    import smac_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int GUARD_W = 48,
    localparam int ACC_W  = 2 * DATA_W,
    localparam int FILL_LO = GUARD_W - DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              in_valid,
    input  logic              op_word,
    input  logic              sat_en,
    input  logic              wr_hi,
    input  logic              wr_lo,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ACC_W-1:0]  mac_result,
    output logic [DATA_W-1:0] acc_hi,
    output logic [DATA_W-1:0] acc_lo
);
    acc_cmd_t          cmd;
    logic [DATA_W-1:0] hi_next, lo_next;

    always_comb begin
        if (clr)           cmd = CMD_CLEAR;
        else if (in_valid) cmd = CMD_MAC;
        else if (wr_hi || wr_lo) cmd = CMD_LOAD;
        else               cmd = CMD_HOLD;
    end

    always_comb begin
        hi_next = acc_hi;
        lo_next = acc_lo;
        unique case (cmd)
            CMD_CLEAR: begin
                hi_next = '0;
                lo_next = '0;
            end
            CMD_MAC: begin
                hi_next = mac_result[ACC_W-1:DATA_W];
                lo_next = mac_result[DATA_W-1:0];
            end
            CMD_LOAD: begin
                if (wr_hi) hi_next = wr_data;
                if (wr_lo) lo_next = wr_data;
            end
            CMD_HOLD: begin
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_hi <= '0;
            acc_lo <= '0;
        end else begin
            acc_hi <= hi_next;
            acc_lo <= lo_next;
        end
    end

    // R1
    reset_zero_chk: assert property (@(posedge clk)
        rst |=> (acc_hi == '0 && acc_lo == '0));

    // R2
    clear_zero_chk: assert property (@(posedge clk) disable iff (rst)
        clr |=> (acc_hi == '0 && acc_lo == '0));

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!clr && !in_valid && !wr_hi && !wr_lo) |=> ($stable(acc_hi) && $stable(acc_lo)));

    // R3
    load_hi_chk: assert property (@(posedge clk) disable iff (rst)
        (!clr && !in_valid && wr_hi) |=> (acc_hi == $past(wr_data)));

    // R6
    long_guard_chk: assert property (@(posedge clk) disable iff (rst)
        (!clr && in_valid && !op_word && sat_en) |=>
            (acc_hi[DATA_W-1:FILL_LO-1] == '0 || acc_hi[DATA_W-1:FILL_LO] == '1));

    // R7
    word_bound_chk: assert property (@(posedge clk) disable iff (rst)
        (!clr && in_valid && op_word && sat_en) |=>
            ((acc_hi == 1 && (acc_lo == {1'b1, {(DATA_W-1){1'b0}}} ||
                              acc_lo == {1'b0, {(DATA_W-1){1'b1}}})) ||
             acc_hi == {DATA_W{acc_lo[DATA_W-1]}}));
endmodule

// File: rtl/smac_unit.sv
module smac_unit #(
    parameter int DATA_W  = 32,
    parameter int HALF_W  = 16,
    parameter int GUARD_W = 48,
    localparam int ACC_W  = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              op_word,
    input  logic              sat_en,
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    input  logic              clr,
    input  logic              wr_hi,
    input  logic              wr_lo,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] acc_hi,
    output logic [DATA_W-1:0] acc_lo
);
    logic [ACC_W-1:0] prod, sum, mac_result;

    smac_mult #(.DATA_W(DATA_W), .HALF_W(HALF_W)) mult_i (
        .op_word (op_word),
        .opa     (opa),
        .opb     (opb),
        .prod    (prod)
    );

    assign sum = {acc_hi, acc_lo} + prod;

    smac_sat #(.DATA_W(DATA_W), .GUARD_W(GUARD_W)) sat_i (
        .sat_en  (sat_en),
        .op_word (op_word),
        .sum     (sum),
        .result  (mac_result)
    );

    smac_acc #(.DATA_W(DATA_W), .GUARD_W(GUARD_W)) acc_i (
        .clk        (clk),
        .rst        (rst),
        .clr        (clr),
        .in_valid   (in_valid),
        .op_word    (op_word),
        .sat_en     (sat_en),
        .wr_hi      (wr_hi),
        .wr_lo      (wr_lo),
        .wr_data    (wr_data),
        .mac_result (mac_result),
        .acc_hi     (acc_hi),
        .acc_lo     (acc_lo)
    );
endmodule

// File: tb/smac_unit_tb_top.sv
`timescale 1ns/1ps
module smac_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst, in_valid, op_word, sat_en, clr, wr_hi, wr_lo;
    logic [31:0] opa, opb, wr_data, acc_hi, acc_lo;

    int n_checks = 0;
    int n_fail   = 0;

    longint m_acc;

    always #10 clk = ~clk;

    smac_unit dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op_word(op_word),
        .sat_en(sat_en), .opa(opa), .opb(opb), .clr(clr), .wr_hi(wr_hi),
        .wr_lo(wr_lo), .wr_data(wr_data), .acc_hi(acc_hi), .acc_lo(acc_lo)
    );

    task automatic compare(string tag);
        logic [63:0] got;
        got = {acc_hi, acc_lo};
        n_checks++;
        if (got !== m_acc) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, m_acc);
        end
    endtask

    // reference behaviour of one clock edge
    function automatic longint model(longint acc, logic r, logic v, logic w,
                                     logic s, logic [31:0] a, logic [31:0] b,
                                     logic c, logic wh, logic wl, logic [31:0] d);
        longint p, res;
        logic [31:0] hi, lo;
        if (r || c) return 0;
        if (v) begin
            if (w) p = longint'($signed(a[15:0])) * longint'($signed(b[15:0]));
            else   p = longint'($signed(a)) * longint'($signed(b));
            res = acc + p;
            hi = res[63:32];
            lo = res[31:0];
            if (s && !w) begin
                if (res < 0) hi = hi | 32'hFFFF0000;
                else         hi = hi & 32'h00007FFF;
            end else if (s && w) begin
                if (res < -64'sd2147483648) begin hi = 1; lo = 32'h80000000; end
                else if (res > 64'sd2147483647) begin hi = 1; lo = 32'h7FFFFFFF; end
            end
            return {hi, lo};
        end
        hi = acc[63:32];
        lo = acc[31:0];
        if (wh) hi = d;
        if (wl) lo = d;
        return {hi, lo};
    endfunction

    task automatic cyc(logic r, logic v, logic w, logic s, logic [31:0] a,
                       logic [31:0] b, logic c, logic wh, logic wl,
                       logic [31:0] d, string tag);
        @(negedge clk);
        rst = r; in_valid = v; op_word = w; sat_en = s; opa = a; opb = b;
        clr = c; wr_hi = wh; wr_lo = wl; wr_data = d;
        m_acc = model(m_acc, r, v, w, s, a, b, c, wh, wl, d);
        @(posedge clk);
        #1;
        compare(tag);
    endtask

    task automatic mac(logic w, logic s, logic [31:0] a, logic [31:0] b, string tag);
        cyc(0, 1, w, s, a, b, 0, 0, 0, 0, tag);
    endtask

    task automatic load(logic wh, logic wl, logic [31:0] d, string tag);
        cyc(0, 0, 0, 0, 0, 0, 0, wh, wl, d, tag);
    endtask

    task automatic clear(string tag);
        cyc(0, 0, 0, 0, 0, 0, 1, 0, 0, 0, tag);
    endtask

    initial begin
        #3_000_000;
        n_fail++;
        n_checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        m_acc = 0;
        rst = 1; in_valid = 0; op_word = 0; sat_en = 0; opa = 0; opb = 0;
        clr = 0; wr_hi = 0; wr_lo = 0; wr_data = 0;
        cyc(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R1 reset");
        cyc(1, 1, 0, 0, 32'd9, 32'd9, 0, 1, 1, 32'h5A5A5A5A, "R1 reset beats all");

        // R4 long form, wrap mode
        mac(0, 0, 32'd3, 32'd5, "R4 small positive");
        mac(0, 0, 32'hFFFFFFF9, 32'd6, "R4 mixed sign");
        mac(0, 0, 32'h80000000, 32'h80000000, "R4 most negative squared");
        clear("R2 clear");

        // R5 word form with garbage in upper halves
        mac(1, 0, 32'hABCD0003, 32'h1234FFFE, "R5 upper halves ignored");
        mac(1, 0, 32'hFFFF8000, 32'h00008000, "R5 min half squared");

        // R3 word loads, then R4 wrap past max
        load(1, 0, 32'h7FFFFFFF, "R3 load high");
        load(0, 1, 32'hFFFFFFFF, "R3 load low");
        mac(0, 0, 32'd1, 32'd1, "R4 wrap to negative");
        load(1, 1, 32'h01020304, "R3 load both");

        // R6 long saturation
        clear("R2 clear");
        load(1, 0, 32'h00012345, "R3 load high");
        mac(0, 1, 32'd1, 32'd1, "R6 positive guard");
        load(1, 0, 32'h80000000, "R3 load high");
        load(0, 1, 32'd5, "R3 load low");
        mac(0, 1, 32'd0, 32'd0, "R6 negative fill");
        mac(0, 1, 32'd2, 32'hFFFFFFFF, "R6 negative fill again");

        // R7 word saturation
        clear("R2 clear");
        load(0, 1, 32'h7FFFFFF0, "R3 load low");
        mac(1, 1, 32'h00000010, 32'h00000001, "R7 above max");
        clear("R2 clear");
        load(1, 0, 32'hFFFFFFFF, "R3 load high");
        load(0, 1, 32'h80000000, "R3 load low");
        mac(1, 1, 32'h0000FFFF, 32'h00000001, "R7 below min");
        clear("R2 clear");
        mac(1, 1, 32'd100, 32'h0000FFFD, "R7 inside range");
        mac(1, 1, 32'h7FFF7FFF, 32'h00007FFF, "R7 inside range positive");

        // R2 / R8 priority and hold
        cyc(0, 1, 0, 0, 32'd7, 32'd7, 1, 1, 1, 32'hDEADBEEF, "R2 clear beats request and load");
        cyc(0, 1, 0, 0, 32'd7, 32'd7, 0, 1, 1, 32'hDEADBEEF, "R8 request beats load");
        cyc(0, 0, 1, 1, 32'hFFFF, 32'hFFFF, 0, 0, 0, 32'h11111111, "R8 idle hold");
        cyc(0, 0, 0, 0, 32'd3, 32'd3, 0, 0, 0, 0, "R8 idle hold again");
        cyc(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R1 reset mid run");

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule